// File: doc/BRIEF.md
# Gated Synchronized Square-Wave Generator

This block turns a fast reference clock into a square wave that runs only while an active-low gate input is held low. The gate may come from any clock domain; it is brought into the reference domain through a flop chain. Each time the gate falls, the wave starts afresh. It always opens with a low half-period of full length, so its phase depends on the gate edge and not on any free-running counter. The half-period is given in reference cycles on a configuration input, and the block captures it when oscillation starts.

There are two clock outputs. While the block oscillates they carry the same waveform in step. When it is stopped they sit at opposite levels: output A low and output B high. Gate release and gate assertion both act after the same fixed number of reference edges. After a stop, the block holds off any restart until one half-period has passed. A gate that is already low when that window closes starts the wave at once, so the outputs never show a runt pulse.

Top module: `gated_square_gen`

## Requirements
- R1: Out of reset and whenever not oscillating, `clk_a` is 0 and `clk_b` is 1.
- R2: When `gate_n` is first sampled low at rising edge k while the block is idle, both outputs are 0 from edge k+2 on.
- R3: While oscillating, `clk_a` and `clk_b` are equal on every cycle.
- R4: While oscillating, each output level lasts exactly H reference cycles, where H is the captured `half_cfg` value; a value of 0 is treated as 1.
- R5: Every start begins with a full low half-period of H cycles, whatever the phase was when the previous run ended.
- R6: When `gate_n` is first sampled high at edge k during oscillation, the outputs are at idle levels from edge k+2 on, even in the middle of a half-period.
- R7: After a stop at edge S, no start happens before edge S+H. If the synchronized gate is low at edge S+H, oscillation starts at that edge.
- R8: `half_cfg` is captured only on a start; changing it during a run has no effect on that run's half-period.
- R9: A gate low pulse that ends before the recovery window closes is dropped, and the outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_n | input | 1 | Active-low run gate, asynchronous to `clk` |
| half_cfg | input | HALF_W | Half-period in reference cycles, 0 means 1 |
| clk_a | output | 1 | Clock output A, idle low |
| clk_b | output | 1 | Clock output B, idle high |

## Verification
Several internal faults show at the ports within a cycle or two. A wrong run flag breaks the equal/complementary relation of the two outputs on the very next cycle. A wrong half-period reload moves the first edge of the run, so the error is visible within H cycles of a start. A short recovery count shows up as a start one or more edges early, right after a stop with the gate held low. A sync chain of the wrong length shifts both the start and stop latencies by a whole cycle. The bench compares both outputs on every clock against a behavioural model that tracks time since start and time since stop. It also measures start and stop latency directly.

// File: rtl/gsq_pkg.sv
package gsq_pkg;
   typedef enum logic [1:0] {
      GSQ_IDLE  = 2'd0,
      GSQ_RUN   = 2'd1,
      GSQ_RECOV = 2'd2
   } gsq_state_e;
endpackage

// File: rtl/gsq_sync.sv
module gsq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial begin
      assert (STAGES >= 2) else $error("gsq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= RST_VAL;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gsq_ctrl.sv
module gsq_ctrl
   import gsq_pkg::*;
#(
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_s_i,
   input  logic [HALF_W-1:0] hlat_i,
   output logic              start_o,
   output logic              run_o
);
   initial begin
      assert (HALF_W >= 1) else $error("gsq_ctrl: HALF_W must be at least 1");
   end

   gsq_state_e        state_q, state_d;
   logic [HALF_W-1:0] rcnt_q, rcnt_d;
   logic              window_done;

   assign window_done = (rcnt_q == '0);

   always_comb begin
      state_d = state_q;
      rcnt_d  = rcnt_q;
      start_o = 1'b0;
      unique case (state_q)
         GSQ_IDLE: begin
            if (!gate_s_i) begin
               state_d = GSQ_RUN;
               start_o = 1'b1;
            end
         end
         GSQ_RUN: begin
            if (gate_s_i) begin
               state_d = GSQ_RECOV;
               rcnt_d  = hlat_i - 1'b1;
            end
         end
         GSQ_RECOV: begin
            if (window_done) begin
               if (!gate_s_i) begin
                  state_d = GSQ_RUN;
                  start_o = 1'b1;
               end else begin
                  state_d = GSQ_IDLE;
               end
            end else begin
               rcnt_d = rcnt_q - 1'b1;
            end
         end
         default: state_d = GSQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= GSQ_IDLE;
         rcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         rcnt_q  <= rcnt_d;
      end
   end

   assign run_o = (state_q == GSQ_RUN);

   AST_RECOV_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GSQ_RECOV && !window_done) |=> (state_q != GSQ_RUN)); // R7

   AST_STOP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GSQ_RUN && gate_s_i) |=> (state_q == GSQ_RECOV)); // R6
endmodule

// File: rtl/gsq_wave.sv
module gsq_wave #(
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              run_i,
   input  logic [HALF_W-1:0] half_cfg_i,
   output logic              phase_o,
   output logic [HALF_W-1:0] hlat_o
);
   localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

   logic [HALF_W-1:0] cnt_q;
   logic [HALF_W-1:0] eff_half;

   assign eff_half = (half_cfg_i == '0) ? ONE : half_cfg_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hlat_o  <= ONE;
         cnt_q   <= '0;
         phase_o <= 1'b0;
      end else if (start_i) begin
         hlat_o  <= eff_half;
         cnt_q   <= eff_half - 1'b1;
         phase_o <= 1'b0;
      end else if (run_i) begin
         if (cnt_q == '0) begin
            phase_o <= ~phase_o;
            cnt_q   <= hlat_o - 1'b1;
         end else begin
            cnt_q   <= cnt_q - 1'b1;
         end
      end
   end

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !start_i && cnt_q != '0) |=> $stable(phase_o)); // R4

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i) |=> $stable(hlat_o)); // R8
endmodule

// File: rtl/gated_square_gen.sv
module gated_square_gen #(
   parameter int HALF_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_n,
   input  logic [HALF_W-1:0] half_cfg,
   output logic              clk_a,
   output logic              clk_b
);
   logic              gate_s;
   logic              start;
   logic              running;
   logic              phase;
   logic [HALF_W-1:0] hlat;

   gsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (gate_n),
      .q_o   (gate_s)
   );

   gsq_ctrl #(.HALF_W(HALF_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_s_i (gate_s),
      .hlat_i   (hlat),
      .start_o  (start),
      .run_o    (running)
   );

   gsq_wave #(.HALF_W(HALF_W)) u_wave (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .run_i      (running),
      .half_cfg_i (half_cfg),
      .phase_o    (phase),
      .hlat_o     (hlat)
   );

   assign clk_a = running & phase;
   assign clk_b = running ? phase : 1'b1;

   AST_IDLE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!running) |-> (clk_a != clk_b)); // R1

   AST_RUN_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (clk_a == clk_b)); // R3

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (!clk_a && !clk_b)); // R5
endmodule

// File: tb/test_gated_square_gen.sv
`timescale 1ns/1ps
module test_gated_square_gen;
   localparam int HALF_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              gate_n = 1'b1;
   logic [HALF_W-1:0] half_cfg = 8'd3;
   logic              clk_a, clk_b;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gated_square_gen #(.HALF_W(HALF_W), .SYNC_STAGES(2)) i_gated_square_gen (
      .clk(clk), .rst_n(rst_n), .gate_n(gate_n), .half_cfg(half_cfg),
      .clk_a(clk_a), .clk_b(clk_b)
   );

   // behavioural reference: mode 0 idle, 1 running, 2 recovery
   int m_mode = 0, m_t = 0, m_rc = 0, m_h = 1;
   bit m_s1 = 1, m_s2 = 1;

   always @(posedge clk) begin
      bit gs;
      if (!rst_n) begin
         m_mode = 0; m_s1 = 1; m_s2 = 1; m_h = 1; m_t = 0; m_rc = 0;
      end else begin
         gs = m_s2;
         case (m_mode)
            0: if (!gs) begin
                  m_mode = 1; m_t = 0; m_h = (half_cfg == 0) ? 1 : int'(half_cfg);
               end
            1: if (gs) begin m_mode = 2; m_rc = 0; end
               else m_t++;
            default: begin
               m_rc++;
               if (m_rc >= m_h) begin
                  if (!gs) begin
                     m_mode = 1; m_t = 0; m_h = (half_cfg == 0) ? 1 : int'(half_cfg);
                  end else m_mode = 0;
               end
            end
         endcase
         m_s2 = m_s1;
         m_s1 = gate_n;
      end
   end

   // cycle comparison against the model
   always @(negedge clk) begin
      logic ea, eb;
      string tag;
      if (m_mode == 1) begin
         ea = logic'((m_t / m_h) % 2); eb = ea; tag = "R4";
      end else begin
         ea = 1'b0; eb = 1'b1; tag = (m_mode == 2) ? "R7" : "R1";
      end
      checks++;
      if (clk_a !== ea || clk_b !== eb) begin
         errors++;
         $display("FAIL %s cycle %0d: a/b=%b%b expected %b%b", tag, cyc, clk_a, clk_b, ea, eb);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: cycles=%0d expected <150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic expect_val(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // drive gate low at a negedge and count rising edges until outputs leave idle
   task automatic start_latency(string tag);
      int n = 0;
      gate_n = 1'b0;
      while (clk_b == 1'b1 && n < 20) begin
         @(posedge clk); n++; @(negedge clk);
      end
      expect_val(tag, n, 3);
   endtask

   task automatic stop_latency(string tag);
      int n = 0;
      gate_n = 1'b1;
      while (clk_a == clk_b && n < 20) begin
         @(posedge clk); n++; @(negedge clk);
      end
      expect_val(tag, n, 3);
   endtask

   initial begin
      wait_cyc(4);
      // R1: idle levels during reset
      expect_val("R1 reset a", int'(clk_a), 0);
      expect_val("R1 reset b", int'(clk_b), 1);
      rst_n = 1'b1;
      wait_cyc(5);

      // R2 start latency and R3/R4 main waveform, H=3
      half_cfg = 8'd3;
      start_latency("R2 start latency H3");
      wait_cyc(30);
      expect_val("R3 equal outputs", int'(clk_a == clk_b), 1);
      // R6: stop latency
      stop_latency("R6 stop latency H3");
      wait_cyc(10);

      // H=1 and H=0 treated as 1 (R4)
      half_cfg = 8'd1;
      gate_n = 1'b0; wait_cyc(20);
      gate_n = 1'b1; wait_cyc(6);
      half_cfg = 8'd0;
      gate_n = 1'b0; wait_cyc(20);
      gate_n = 1'b1; wait_cyc(6);

      // R6: release in the middle of a half-period, H=5
      half_cfg = 8'd5;
      gate_n = 1'b0; wait_cyc(15);
      stop_latency("R6 mid half-period stop");
      wait_cyc(10);

      // R5: restart realigns phase after ending in the high phase
      half_cfg = 8'd4;
      gate_n = 1'b0; wait_cyc(8);
      gate_n = 1'b1; wait_cyc(8);
      start_latency("R5 restart begins low");
      wait_cyc(3);
      expect_val("R5 first half low", int'(clk_a), 0);
      gate_n = 1'b1; wait_cyc(10);

      // R8: configuration change during a run is ignored
      half_cfg = 8'd2;
      gate_n = 1'b0; wait_cyc(6);
      half_cfg = 8'd7; wait_cyc(20);
      gate_n = 1'b1; wait_cyc(10);

      // R7: fall inside recovery window held off, H=6
      half_cfg = 8'd6;
      gate_n = 1'b0; wait_cyc(20);
      gate_n = 1'b1; wait_cyc(2);
      gate_n = 1'b0; wait_cyc(4);
      expect_val("R7 held off during window", int'(clk_b), 1);
      wait_cyc(12);
      expect_val("R7 started after window", int'(clk_a == clk_b), 1);
      gate_n = 1'b1; wait_cyc(12);

      // R9: short pulse ending inside recovery window is dropped, H=8
      half_cfg = 8'd8;
      gate_n = 1'b0; wait_cyc(20);
      gate_n = 1'b1; wait_cyc(1);
      gate_n = 1'b0; wait_cyc(2);
      gate_n = 1'b1; wait_cyc(15);
      expect_val("R9 dropped pulse a", int'(clk_a), 0);
      expect_val("R9 dropped pulse b", int'(clk_b), 1);

      wait_cyc(5);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule